// File: doc/BRIEF.md
# Dual-Space On-Chip Memory with Relocatable Block

This block is the on-chip memory of a Harvard-style 16-bit signal processor. A program-side port and a data-side port work independently, and both can complete an access in the same clock cycle. Program space holds a 4096-word main RAM. Data space holds three RAM blocks: a 32-word scratch block, a first 256-word bank and a second 256-word bank. All accesses complete with no wait states. Read data appears one cycle after the request.

The first 256-word bank can be relocated. Two command strobes move it between data space and program space while the processor runs. At any moment it answers only the bus that currently owns it. An access to it from the other bus is handled as an access to an unmapped address.

A data address can be formed in two ways. In direct mode it is a 9-bit page pointer joined with the low 7 bits of the instruction word. In indirect mode it is the value of the auxiliary register that the caller has selected. A data access to a location that maps to nothing reads zero, has no effect on any storage, and raises a one-cycle flag.

Top module: `dsp_dual_mem`

## Requirements
- R1: While `rst_n` is low, and after it is released, `b0_prog` is 0 (relocatable bank in data space). `d_rdata`, `p_rdata` and `d_unmapped` are 0 until a read is made.
- R2: With `d_indirect`=0 the data address is `{d_page, d_instr[6:0]}`, and bits 15:7 of `d_instr` are ignored. With `d_indirect`=1 the data address is `d_aux`.
- R3: Data space map: the scratch block is at 0x0060–0x007F, the second bank at 0x0300–0x03FF, and the relocatable bank at 0x0200–0x02FF while `b0_prog`=0. A read returns, in the next cycle, the last word written to that location.
- R4: The main program RAM is at program addresses 0x0000–0x0FFF. A program read returns, in the next cycle, the last word written there.
- R5: A `cfg_prog` strobe alone sets `b0_prog` at the next clock edge. A `cfg_data` strobe alone clears it. Both strobes together, or neither, leave it unchanged. An access made in the same cycle as the strobe still uses the old mapping. The next access uses the new mapping.
- R6: While `b0_prog`=1, the relocatable bank appears at program addresses 0xFF00–0xFFFF, and data accesses to 0x0200–0x02FF act as unmapped. While `b0_prog`=0, program reads of 0xFF00–0xFFFF return 0, and program writes there change nothing.
- R7: A data access to an unmapped address returns 0 and writes nothing. `d_unmapped` is 1 in the cycle after that access and 0 after any mapped access.
- R8: A program access outside the mapped program ranges returns 0 and writes nothing.
- R9: A program access and a data access issued in the same cycle both complete, and each returns its own word.
- R10: In the cycle after a port was idle or performed a write, its read-data output is 0.
- R11: The relocatable bank keeps its contents across mode changes. A word written through one bus can be read through the other bus after relocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_prog | input | 1 | Strobe: move relocatable bank to program space |
| cfg_data | input | 1 | Strobe: move relocatable bank to data space |
| b0_prog | output | 1 | Mode flag, 1 = relocatable bank in program space |
| p_en | input | 1 | Program-side access request |
| p_we | input | 1 | Program-side write (1) or read (0) |
| p_addr | input | 16 | Program address |
| p_wdata | input | 16 | Program write data |
| p_rdata | output | 16 | Program read data, one cycle after request |
| d_en | input | 1 | Data-side access request |
| d_we | input | 1 | Data-side write (1) or read (0) |
| d_indirect | input | 1 | 1 = indirect addressing via `d_aux` |
| d_page | input | 9 | Data page pointer (direct mode) |
| d_instr | input | 16 | Instruction word, low 7 bits are the offset |
| d_aux | input | 16 | Selected auxiliary register value |
| d_wdata | input | 16 | Data write data |
| d_rdata | output | 16 | Data read data, one cycle after request |
| d_unmapped | output | 1 | One-cycle flag: previous data access hit no block |

## Verification
Two things can land in the same cycle: a mode-change strobe and an access to the relocatable bank. The bench issues a data read of 0x0205 in the same cycle as the `cfg_prog` strobe. That read must still return the stored word. The next data read of the same address must return zero with the flag raised, and a program read of 0xFF05 must return the word. The second pairing is concurrent program and data traffic. Every data read in the full data-address sweep is paired with a program read in the same cycle, and both results are compared with arithmetic patterns.

// File: rtl/dsp_mem_pkg.sv
// Package: shared region codes for the dual-space memory.
// Assumes: one region code per bus, decoded each cycle.
package dsp_mem_pkg;
    // data-side target block
    typedef enum logic [1:0] {DR_NONE, DR_BANK0, DR_BANK1, DR_SCR} dregion_t;
    // program-side target block
    typedef enum logic [1:0] {PR_NONE, PR_MAIN, PR_BANK0} pregion_t;
endpackage

// File: rtl/dmem_addr_gen.sv
// Data address former: direct (page pointer + instruction offset) or
// indirect (auxiliary register value). Assumes PAGE_W + OFS_W == AW.
module dmem_addr_gen #(
    parameter int AW     = 16,
    parameter int PAGE_W = 9,
    localparam int OFS_W = AW - PAGE_W
) (
    input  logic              indirect,
    input  logic [PAGE_W-1:0] page,
    input  logic [AW-1:0]     instr,
    input  logic [AW-1:0]     aux,
    output logic [AW-1:0]     addr
);
    // pick the address source
    always_comb begin
        if (indirect) addr = aux;
        else          addr = {page, instr[OFS_W-1:0]};
    end
endmodule

// File: rtl/dmem_decode.sv
// Address decoder for both buses. The relocatable bank is decoded only on
// the bus that owns it. Assumes every base is aligned to its block size
// and that all depths are powers of two.
module dmem_decode
    import dsp_mem_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          PROG_DEPTH = 4096,
    parameter int          BANK_DEPTH = 256,
    parameter int          SCR_DEPTH  = 32,
    parameter logic [AW-1:0] BANK0_DBASE = 16'h0200,
    parameter logic [AW-1:0] BANK1_DBASE = 16'h0300,
    parameter logic [AW-1:0] SCR_DBASE   = 16'h0060,
    parameter logic [AW-1:0] BANK0_PBASE = 16'hFF00
) (
    input  logic          b0_prog,
    input  logic [AW-1:0] d_addr,
    input  logic [AW-1:0] p_addr,
    output dregion_t      d_region,
    output pregion_t      p_region
);
    localparam int PROG_LG = $clog2(PROG_DEPTH);
    localparam int BANK_LG = $clog2(BANK_DEPTH);
    localparam int SCR_LG  = $clog2(SCR_DEPTH);

    logic d_in_b0, d_in_b1, d_in_scr, p_in_main, p_in_b0;

    // compare upper address bits with each window base
    always_comb begin
        d_in_b0   = (d_addr >> BANK_LG) == (BANK0_DBASE >> BANK_LG);
        d_in_b1   = (d_addr >> BANK_LG) == (BANK1_DBASE >> BANK_LG);
        d_in_scr  = (d_addr >> SCR_LG)  == (SCR_DBASE >> SCR_LG);
        p_in_main = (p_addr >> PROG_LG) == '0;
        p_in_b0   = (p_addr >> BANK_LG) == (BANK0_PBASE >> BANK_LG);
    end

    // data-side region; bank0 only while owned by data space
    always_comb begin
        if (d_in_scr)                d_region = DR_SCR;
        else if (d_in_b1)            d_region = DR_BANK1;
        else if (d_in_b0 && !b0_prog) d_region = DR_BANK0;
        else                         d_region = DR_NONE;
    end

    // program-side region; bank0 only while owned by program space
    always_comb begin
        if (p_in_main)               p_region = PR_MAIN;
        else if (p_in_b0 && b0_prog) p_region = PR_BANK0;
        else                         p_region = PR_NONE;
    end
endmodule

// File: rtl/dmem_spram.sv
// Single-port synchronous RAM, one-cycle read latency, read-before-write.
// Assumes a single requester per cycle.
module dmem_spram #(
    parameter int DW    = 16,
    parameter int DEPTH = 256,
    localparam int LG   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [LG-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // storage write and registered read
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/dsp_dual_mem.sv
// Dual-space on-chip memory: main program RAM, two data banks (the first
// relocatable into program space) and a scratch block. Both buses may
// access in the same cycle. Mode changes apply from the next cycle.
// Assumes synchronous active-low reset; RAM contents are not reset.
module dsp_dual_mem
    import dsp_mem_pkg::*;
#(
    parameter int DW         = 16,
    parameter int AW         = 16,
    parameter int PAGE_W     = 9,
    parameter int PROG_DEPTH = 4096,
    parameter int BANK_DEPTH = 256,
    parameter int SCR_DEPTH  = 32,
    parameter logic [AW-1:0] BANK0_DBASE = 16'h0200,
    parameter logic [AW-1:0] BANK1_DBASE = 16'h0300,
    parameter logic [AW-1:0] SCR_DBASE   = 16'h0060,
    parameter logic [AW-1:0] BANK0_PBASE = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_prog,
    input  logic              cfg_data,
    output logic              b0_prog,
    input  logic              p_en,
    input  logic              p_we,
    input  logic [AW-1:0]     p_addr,
    input  logic [DW-1:0]     p_wdata,
    output logic [DW-1:0]     p_rdata,
    input  logic              d_en,
    input  logic              d_we,
    input  logic              d_indirect,
    input  logic [PAGE_W-1:0] d_page,
    input  logic [AW-1:0]     d_instr,
    input  logic [AW-1:0]     d_aux,
    input  logic [DW-1:0]     d_wdata,
    output logic [DW-1:0]     d_rdata,
    output logic              d_unmapped
);
    localparam int PROG_LG = $clog2(PROG_DEPTH);
    localparam int BANK_LG = $clog2(BANK_DEPTH);
    localparam int SCR_LG  = $clog2(SCR_DEPTH);

    logic [AW-1:0] d_addr;
    dregion_t      d_region, d_sel_q;
    pregion_t      p_region, p_sel_q;
    logic          mode_q, unm_q;

    logic               b0_en, b0_we;
    logic [BANK_LG-1:0] b0_addr;
    logic [DW-1:0]      b0_wdata, b0_rd, b1_rd, scr_rd, main_rd;

    dmem_addr_gen #(.AW(AW), .PAGE_W(PAGE_W)) i_agen (
        .indirect (d_indirect),
        .page     (d_page),
        .instr    (d_instr),
        .aux      (d_aux),
        .addr     (d_addr)
    );

    dmem_decode #(
        .AW(AW), .PROG_DEPTH(PROG_DEPTH), .BANK_DEPTH(BANK_DEPTH),
        .SCR_DEPTH(SCR_DEPTH), .BANK0_DBASE(BANK0_DBASE),
        .BANK1_DBASE(BANK1_DBASE), .SCR_DBASE(SCR_DBASE),
        .BANK0_PBASE(BANK0_PBASE)
    ) i_dec (
        .b0_prog  (mode_q),
        .d_addr   (d_addr),
        .p_addr   (p_addr),
        .d_region (d_region),
        .p_region (p_region)
    );

    // ownership flag of the relocatable bank; conflicting strobes hold it
    always_ff @(posedge clk) begin
        if (!rst_n)                  mode_q <= 1'b0;
        else if (cfg_prog ^ cfg_data) mode_q <= cfg_prog;
    end
    assign b0_prog = mode_q;

    // steer the relocatable bank's single port to its owning bus
    always_comb begin
        if (mode_q) begin
            b0_en    = p_en && (p_region == PR_BANK0);
            b0_we    = p_we;
            b0_addr  = p_addr[BANK_LG-1:0];
            b0_wdata = p_wdata;
        end else begin
            b0_en    = d_en && (d_region == DR_BANK0);
            b0_we    = d_we;
            b0_addr  = d_addr[BANK_LG-1:0];
            b0_wdata = d_wdata;
        end
    end

    dmem_spram #(.DW(DW), .DEPTH(BANK_DEPTH)) i_bank0 (
        .clk(clk), .en(b0_en), .we(b0_we), .addr(b0_addr),
        .wdata(b0_wdata), .rdata(b0_rd)
    );

    dmem_spram #(.DW(DW), .DEPTH(BANK_DEPTH)) i_bank1 (
        .clk(clk), .en(d_en && (d_region == DR_BANK1)), .we(d_we),
        .addr(d_addr[BANK_LG-1:0]), .wdata(d_wdata), .rdata(b1_rd)
    );

    dmem_spram #(.DW(DW), .DEPTH(SCR_DEPTH)) i_scr (
        .clk(clk), .en(d_en && (d_region == DR_SCR)), .we(d_we),
        .addr(d_addr[SCR_LG-1:0]), .wdata(d_wdata), .rdata(scr_rd)
    );

    dmem_spram #(.DW(DW), .DEPTH(PROG_DEPTH)) i_main (
        .clk(clk), .en(p_en && (p_region == PR_MAIN)), .we(p_we),
        .addr(p_addr[PROG_LG-1:0]), .wdata(p_wdata), .rdata(main_rd)
    );

    // remember which block answers each read, and flag unmapped data hits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_sel_q <= DR_NONE;
            p_sel_q <= PR_NONE;
            unm_q   <= 1'b0;
        end else begin
            d_sel_q <= (d_en && !d_we) ? d_region : DR_NONE;
            p_sel_q <= (p_en && !p_we) ? p_region : PR_NONE;
            unm_q   <= d_en && (d_region == DR_NONE);
        end
    end
    assign d_unmapped = unm_q;

    // data read-return mux
    always_comb begin
        case (d_sel_q)
            DR_BANK0: d_rdata = b0_rd;
            DR_BANK1: d_rdata = b1_rd;
            DR_SCR:   d_rdata = scr_rd;
            default:  d_rdata = '0;
        endcase
    end

    // program read-return mux
    always_comb begin
        case (p_sel_q)
            PR_MAIN:  p_rdata = main_rd;
            PR_BANK0: p_rdata = b0_rd;
            default:  p_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dsp_dual_mem_chk.sv
// Checker for dsp_dual_mem: mode strobes, lockout, unmapped and idle
// behaviour. Recomputes the data address from the raw inputs.
module dsp_dual_mem_chk #(
    parameter int DW     = 16,
    parameter int AW     = 16,
    parameter int PAGE_W = 9,
    parameter int BANK_DEPTH = 256,
    parameter logic [AW-1:0] BANK0_DBASE = 16'h0200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_prog,
    input logic              cfg_data,
    input logic              b0_prog,
    input logic              p_en,
    input logic [DW-1:0]     p_rdata,
    input logic              d_en,
    input logic              d_indirect,
    input logic [PAGE_W-1:0] d_page,
    input logic [AW-1:0]     d_instr,
    input logic [AW-1:0]     d_aux,
    input logic [DW-1:0]     d_rdata,
    input logic              d_unmapped
);
    localparam int BANK_LG = $clog2(BANK_DEPTH);
    localparam int OFS_W   = AW - PAGE_W;

    logic [AW-1:0] chk_addr;
    logic          chk_in_b0;
    // independent address and bank0 window computation
    always_comb begin
        chk_addr  = d_indirect ? d_aux : {d_page, d_instr[OFS_W-1:0]};
        chk_in_b0 = (chk_addr >> BANK_LG) == (BANK0_DBASE >> BANK_LG);
    end

    p_cfg_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_prog && !cfg_data) |=> b0_prog);
    p_cfg_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_data && !cfg_prog) |=> !b0_prog);
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_prog == cfg_data) |=> $stable(b0_prog));
    p_lockout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (d_en && b0_prog && chk_in_b0) |=> (d_unmapped && d_rdata == '0));
    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        d_unmapped |-> d_rdata == '0);
    p_idle_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !d_en |=> (d_rdata == '0 && !d_unmapped));
    p_idle_prog_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !p_en |=> p_rdata == '0);
endmodule

bind dsp_dual_mem dsp_dual_mem_chk #(
    .DW(DW), .AW(AW), .PAGE_W(PAGE_W), .BANK_DEPTH(BANK_DEPTH),
    .BANK0_DBASE(BANK0_DBASE)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_prog(cfg_prog), .cfg_data(cfg_data),
    .b0_prog(b0_prog), .p_en(p_en), .p_rdata(p_rdata), .d_en(d_en),
    .d_indirect(d_indirect), .d_page(d_page), .d_instr(d_instr),
    .d_aux(d_aux), .d_rdata(d_rdata), .d_unmapped(d_unmapped)
);

// File: tb/test_dsp_dual_mem.sv
// Bench: full sweeps of program and data address ranges with arithmetic
// patterns, plus mode-change corner cases.
module test_dsp_dual_mem;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_prog = 1'b0, cfg_data = 1'b0, b0_prog;
    logic        p_en = 1'b0, p_we = 1'b0;
    logic [15:0] p_addr = '0, p_wdata = '0, p_rdata;
    logic        d_en = 1'b0, d_we = 1'b0, d_indirect = 1'b0;
    logic [8:0]  d_page = '0;
    logic [15:0] d_instr = '0, d_aux = '0, d_wdata = '0, d_rdata;
    logic        d_unmapped;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    dsp_dual_mem i_dsp_dual_mem (
        .clk(clk), .rst_n(rst_n), .cfg_prog(cfg_prog), .cfg_data(cfg_data),
        .b0_prog(b0_prog), .p_en(p_en), .p_we(p_we), .p_addr(p_addr),
        .p_wdata(p_wdata), .p_rdata(p_rdata), .d_en(d_en), .d_we(d_we),
        .d_indirect(d_indirect), .d_page(d_page), .d_instr(d_instr),
        .d_aux(d_aux), .d_wdata(d_wdata), .d_rdata(d_rdata),
        .d_unmapped(d_unmapped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] dpat(input int a);
        return 16'(a * 37 + 16'h5A3C);
    endfunction
    function automatic logic [15:0] ppat(input int a);
        return 16'(a * 113) ^ 16'hC3A5;
    endfunction
    function automatic bit dmapped(input int a, input bit mode);
        return (a >= 'h60 && a <= 'h7F) || (a >= 'h300 && a <= 'h3FF) ||
               (!mode && a >= 'h200 && a <= 'h2FF);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // set up a data access; even addresses direct, odd indirect
    task automatic dset(input bit en, input bit we, input logic [15:0] a, input logic [15:0] wd);
        d_en = en; d_we = we; d_wdata = wd;
        d_indirect = a[0];
        d_page = a[15:7];
        d_instr = {9'h1A5, a[6:0]};
        d_aux = a[0] ? a : 16'hDEAD;
    endtask

    task automatic pset(input bit en, input bit we, input logic [15:0] a, input logic [15:0] wd);
        p_en = en; p_we = we; p_addr = a; p_wdata = wd;
    endtask

    initial begin
        logic [15:0] exp0205;
        // R1: reset state
        tick(); tick();
        check("R1 b0_prog in reset", {31'd0, b0_prog}, 32'd0);
        check("R1 d_rdata in reset", {16'd0, d_rdata}, 32'd0);
        rst_n = 1'b1;
        tick();
        check("R1 b0_prog after reset", {31'd0, b0_prog}, 32'd0);
        check("R1 unmapped after reset", {31'd0, d_unmapped}, 32'd0);
        check("R1 p_rdata after reset", {16'd0, p_rdata}, 32'd0);

        // R4: fill main program RAM
        for (int a = 0; a < 4096; a++) begin
            pset(1'b1, 1'b1, 16'(a), ppat(a));
            tick();
            check("R10 p_rdata after write", {16'd0, p_rdata}, 32'd0);
        end
        pset(1'b0, 1'b0, '0, '0);

        // R2 R3 R7: write sweep over data space
        for (int a = 0; a < 'h480; a++) begin
            dset(1'b1, 1'b1, 16'(a), dpat(a));
            tick();
            check("R7 flag on write", {31'd0, d_unmapped}, {31'd0, !dmapped(a, 1'b0)});
            check("R10 d_rdata after write", {16'd0, d_rdata}, 32'd0);
        end
        // R7: unmapped aliases of mapped rows write nothing
        dset(1'b1, 1'b1, 16'h8265, 16'hFFFF); tick();
        dset(1'b1, 1'b1, 16'h1060, 16'hFFFF); tick();
        check("R7 alias flagged", {31'd0, d_unmapped}, 32'd1);

        // R9 R3 R4: read sweep with concurrent program reads
        for (int a = 0; a < 'h480; a++) begin
            dset(1'b1, 1'b0, 16'(a), '0);
            pset(1'b1, 1'b0, 16'((a * 7) & 'hFFF), '0);
            tick();
            check("R3 R9 data read", {16'd0, d_rdata},
                  dmapped(a, 1'b0) ? {16'd0, dpat(a)} : 32'd0);
            check("R7 flag on read", {31'd0, d_unmapped}, {31'd0, !dmapped(a, 1'b0)});
            check("R4 R9 prog read", {16'd0, p_rdata}, {16'd0, ppat((a * 7) & 'hFFF)});
        end
        // R4: rest of program RAM
        for (int a = 0; a < 4096; a++) begin
            dset(1'b0, 1'b0, '0, '0);
            pset(1'b1, 1'b0, 16'(a), '0);
            tick();
            check("R4 prog read", {16'd0, p_rdata}, {16'd0, ppat(a)});
            check("R10 idle data", {16'd0, d_rdata}, 32'd0);
        end

        // R2: direct mode ignores instruction high bits
        d_en = 1'b1; d_we = 1'b0; d_indirect = 1'b0; d_page = 9'h006;
        d_instr = 16'hFF85; d_aux = 16'h0060;
        tick();
        check("R2 direct offset", {16'd0, d_rdata}, {16'd0, dpat('h305)});
        d_indirect = 1'b1; d_page = 9'h000;
        tick();
        check("R2 indirect aux", {16'd0, d_rdata}, {16'd0, dpat('h60)});

        // R8: unmapped program address
        dset(1'b0, 1'b0, '0, '0);
        pset(1'b1, 1'b1, 16'h2000, 16'h1111); tick();
        pset(1'b1, 1'b0, 16'h2000, '0); tick();
        check("R8 prog unmapped", {16'd0, p_rdata}, 32'd0);
        // R6: locked-out program window while in data mode
        pset(1'b1, 1'b1, 16'hFF05, 16'h2222); tick();
        pset(1'b1, 1'b0, 16'hFF05, '0); tick();
        check("R6 prog window locked", {16'd0, p_rdata}, 32'd0);
        pset(1'b0, 1'b0, '0, '0);

        // R5: strobe and data read in same cycle use the old mapping
        cfg_prog = 1'b1;
        dset(1'b1, 1'b0, 16'h0205, '0);
        tick();
        cfg_prog = 1'b0;
        check("R5 same-cycle read old map", {16'd0, d_rdata}, {16'd0, dpat('h205)});
        check("R5 mode set", {31'd0, b0_prog}, 32'd1);
        tick();
        check("R6 data locked out", {16'd0, d_rdata}, 32'd0);
        check("R6 data lock flag", {31'd0, d_unmapped}, 32'd1);
        // R11: bank content visible on program side (write at 0xFF05 was dropped)
        dset(1'b0, 1'b0, '0, '0);
        pset(1'b1, 1'b0, 16'hFF05, '0); tick();
        check("R11 content kept", {16'd0, p_rdata}, {16'd0, dpat('h205)});
        exp0205 = 16'hBEEF;
        pset(1'b1, 1'b1, 16'hFF05, exp0205); tick();
        pset(1'b1, 1'b0, 16'hFF05, '0); tick();
        check("R6 prog window write", {16'd0, p_rdata}, {16'd0, exp0205});
        pset(1'b0, 1'b0, '0, '0);
        // R5: both strobes hold the mode
        cfg_prog = 1'b1; cfg_data = 1'b1; tick();
        cfg_prog = 1'b0; cfg_data = 1'b0;
        check("R5 both strobes hold", {31'd0, b0_prog}, 32'd1);
        tick();
        check("R5 no strobe hold", {31'd0, b0_prog}, 32'd1);
        // R5: back to data space
        cfg_data = 1'b1; tick(); cfg_data = 1'b0;
        check("R5 mode clear", {31'd0, b0_prog}, 32'd0);
        dset(1'b1, 1'b0, 16'h0205, '0); tick();
        check("R11 write from program seen on data", {16'd0, d_rdata}, {16'd0, exp0205});
        check("R7 flag clear mapped", {31'd0, d_unmapped}, 32'd0);
        dset(1'b0, 1'b0, '0, '0); tick();
        check("R10 idle after read", {16'd0, d_rdata}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule